// File: doc/BRIEF.md
# Boundary Test Pattern and Signature Engine

This block is the pattern side of a boundary-scan buffer with an 18-bit data path. One shared register either compacts the values on the data inputs into a running signature, or drives the data outputs with a generated pattern. The available patterns are a pseudo-random sequence, an incrementing binary count, and an inverted copy of a sampled input word. A mode code chosen by the test controller's current instruction selects which job the register does.

The register advances once per test clock while the controller sits in its run/idle state and a valid mode is selected. While the controller is in its data-shift state, the register instead forms a serial path from the test data input toward the test data output. Software uses this path to seed the register and to read back a signature. Every update is clocked by the test clock. The controller state machine and the pad drivers sit outside this block.

Top module: `tpe_top`

## Requirements
- R1: While reset is held, and after it is released with no stimulus applied, `pat_out` reads all zeros and `tdo` reads 0.
- R2: With `shift_dr` high, each clock moves the register one place toward bit 0 and loads `tdi` into bit 17. `tdo` always shows bit 0 of the register.
- R3: If `shift_dr` and `run_idle` are high in the same cycle, only the shift takes place and the pattern step is suppressed.
- R4: The register holds its value unless it is shifting or stepping. A step needs `run_idle` high and a mode code of 1 to 4; codes 0, 5, 6 and 7 never step.
- R5: Mode 1 (signature) step: shift the register left one place; if the old bit 17 was 1, XOR in the feedback mask 0x00801 (polynomial x^18 + x^11 + 1); then XOR in `data_in`.
- R6: Mode 2 (pseudo-random) step: the same Galois shift as R5 without `data_in`. A register that is all zeros becomes all ones instead.
- R7: Mode 3 (count) step: add one to the register, wrapping from 0x3FFFF to 0.
- R8: Mode 4 (toggle) step: the first step after entering mode 4 loads `data_in`, and every later step inverts the register. Selecting any other mode re-arms the load.
- R9: `pat_out` always equals the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all updates on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_idle | input | 1 | Controller is in its run/idle state |
| shift_dr | input | 1 | Controller is in its data-shift state |
| mode | input | 3 | 0 off, 1 signature, 2 pseudo-random, 3 count, 4 toggle |
| tdi | input | 1 | Serial data into bit 17 |
| data_in | input | 18 | Sampled data inputs |
| tdo | output | 1 | Serial data out, bit 0 of the register |
| pat_out | output | 18 | Pattern driven to the data outputs |

## Verification
A shift and a pattern step can be requested in the same cycle: a malformed controller may raise `run_idle` and `shift_dr` together. The bench raises both signals together in the middle of a pseudo-random run. The reference model shifts only, and the bench compares every cycle. A wrong priority shows up at once in `pat_out`, and again when the stream is read back through `tdo`. Toggle arming is also crossed with shifting: a seed shifted in while mode 4 is armed must be inverted on the next step, not reloaded from `data_in`.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int unsigned TPE_W = 18;
  localparam logic [TPE_W-1:0] TPE_MASK = 18'h00801;

  typedef enum logic [2:0] {
    TPE_OFF    = 3'd0,
    TPE_PSA    = 3'd1,
    TPE_PRPG   = 3'd2,
    TPE_COUNT  = 3'd3,
    TPE_TOGGLE = 3'd4
  } tpe_mode_e;
endpackage

// File: rtl/tpe_rst_sync.sv
module tpe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/tpe_galois.sv
module tpe_galois #(
  parameter int unsigned W = 18,
  parameter logic [W-1:0] MASK = 18'h00801
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1];

  assign nxt[0] = fb & MASK[0];
  for (genvar i = 1; i < W; i++) begin : g_tap
    assign nxt[i] = cur[i-1] ^ (fb & MASK[i]);
  end
endmodule

// File: rtl/tpe_next.sv
module tpe_next
  import tpe_pkg::*;
#(
  parameter int unsigned W = TPE_W,
  parameter logic [W-1:0] MASK = TPE_MASK
) (
  input  tpe_mode_e    mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pins,
  input  logic         armed,
  output logic [W-1:0] nxt,
  output logic         valid
);
  logic [W-1:0] gal;

  tpe_galois #(.W(W), .MASK(MASK)) u_gal (
    .cur (cur),
    .nxt (gal)
  );

  always_comb begin
    nxt   = cur;
    valid = 1'b1;
    case (mode)
      TPE_PSA:    nxt = gal ^ pins;
      TPE_PRPG:   nxt = (cur == '0) ? '1 : gal;
      TPE_COUNT:  nxt = cur + W'(1);
      TPE_TOGGLE: nxt = armed ? ~cur : pins;
      default:    valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/tpe_top.sv
module tpe_top
  import tpe_pkg::*;
#(
  parameter int unsigned W = TPE_W,
  parameter logic [W-1:0] MASK = TPE_MASK
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         run_idle,
  input  logic         shift_dr,
  input  logic [2:0]   mode,
  input  logic         tdi,
  input  logic [W-1:0] data_in,
  output logic         tdo,
  output logic [W-1:0] pat_out
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic         rst_n_i;
  tpe_mode_e    mode_m;
  logic [W-1:0] pat_q, pat_d, step_val;
  logic         armed_q, armed_d;
  logic         mode_ok, step, pat_en;

  assign mode_m = tpe_mode_e'(mode);

  tpe_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_i)
  );

  tpe_next #(.W(W), .MASK(MASK)) u_next (
    .mode  (mode_m),
    .cur   (pat_q),
    .pins  (data_in),
    .armed (armed_q),
    .nxt   (step_val),
    .valid (mode_ok)
  );

  // next-state
  always_comb begin
    step   = run_idle & mode_ok & ~shift_dr;
    pat_en = shift_dr | step;
    if (shift_dr) pat_d = {tdi, pat_q[W-1:1]};
    else          pat_d = step_val;
    if (mode_m != TPE_TOGGLE) armed_d = 1'b0;
    else                      armed_d = armed_q | step;
  end

  // registers
  always_ff @(posedge tck or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pat_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (pat_en) pat_q <= pat_d;
      armed_q <= armed_d;
    end
  end

  assign pat_out = pat_q;
  assign tdo     = pat_q[0];

  AST_SHIFT_PATH: assert property (@(posedge tck) disable iff (!rst_n_i)
    shift_dr |=> (pat_q[W-2:0] == $past(pat_q[W-1:1])) && (pat_q[W-1] == $past(tdi))); // R2
  AST_SHIFT_WINS: assert property (@(posedge tck) disable iff (!rst_n_i)
    (shift_dr && run_idle) |=> pat_q[W-2:0] == $past(pat_q[W-1:1])); // R3
  AST_HOLD_QUIET: assert property (@(posedge tck) disable iff (!rst_n_i)
    (!shift_dr && !run_idle) |=> $stable(pat_q)); // R4
  AST_PRPG_NONZERO: assert property (@(posedge tck) disable iff (!rst_n_i)
    (run_idle && !shift_dr && mode_m == TPE_PRPG) |=> pat_q != '0); // R6
  AST_COUNT_WRAP: assert property (@(posedge tck) disable iff (!rst_n_i)
    (run_idle && !shift_dr && mode_m == TPE_COUNT && pat_q == ALL_ONES) |=> pat_q == '0); // R7
  AST_TOGGLE_INV: assert property (@(posedge tck) disable iff (!rst_n_i)
    (run_idle && !shift_dr && mode_m == TPE_TOGGLE && armed_q) |=> pat_q == ~$past(pat_q)); // R8
endmodule

// File: tb/tb_tpe_top.sv
module tb_tpe_top;
  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        run_idle = 1'b0;
  logic        shift_dr = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        tdi = 1'b0;
  logic [17:0] data_in = '0;
  logic        tdo;
  logic [17:0] pat_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [17:0] m_pat;
  bit          m_arm;

  always #4 tck = ~tck;

  tpe_top dut (
    .tck(tck), .trst_n(trst_n), .run_idle(run_idle), .shift_dr(shift_dr),
    .mode(mode), .tdi(tdi), .data_in(data_in), .tdo(tdo), .pat_out(pat_out)
  );

  function automatic logic [17:0] mgal(logic [17:0] r);
    int v;
    v = (int'(r) * 2) % 262144;
    if (int'(r) >= 131072) v = v ^ 'h801;
    return v[17:0];
  endfunction

  // reference model
  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_pat <= '0;
      m_arm <= 0;
    end else begin
      bit stp;
      stp = run_idle && !shift_dr && (mode >= 1) && (mode <= 4);
      if (shift_dr) m_pat <= {tdi, m_pat[17:1]};
      else if (stp) begin
        case (mode)
          3'd1: m_pat <= mgal(m_pat) ^ data_in;
          3'd2: m_pat <= (m_pat == 0) ? 18'h3FFFF : mgal(m_pat);
          3'd3: m_pat <= 18'((int'(m_pat) + 1) % 262144);
          default: m_pat <= m_arm ? ~m_pat : data_in;
        endcase
      end
      m_arm <= (mode == 3'd4) ? (m_arm || stp) : 0;
    end
  end

  // compare every cycle, between edges
  always @(negedge tck) begin
    if (!done) begin
      checks++;
      if (pat_out !== m_pat || tdo !== m_pat[0]) begin
        errors++;
        $display("FAIL %s: pat_out=%h tdo=%b expected pat_out=%h tdo=%b",
                 tag, pat_out, tdo, m_pat, m_pat[0]);
      end
    end
  end

  task automatic cyc(bit ri, bit sh, logic [2:0] md, bit ti, logic [17:0] din);
    @(negedge tck); #1;
    run_idle = ri; shift_dr = sh; mode = md; tdi = ti; data_in = din;
  endtask

  task automatic seed(logic [17:0] v, logic [2:0] md);
    for (int i = 0; i < 18; i++) cyc(0, 1, md, v[i], '0);
    cyc(0, 0, md, 0, '0);
  endtask

  task automatic run(logic [2:0] md, int n);
    for (int i = 0; i < n; i++) cyc(1, 0, md, 0, 18'($urandom));
  endtask

  task automatic readback(logic [2:0] md);
    for (int i = 0; i < 18; i++) cyc(0, 1, md, 1'($urandom), '0);
    cyc(0, 0, md, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    tag = "R1";
    checks++;
    if (pat_out !== '0 || tdo !== 1'b0) begin
      errors++;
      $display("FAIL R1: pat_out=%h tdo=%b expected 00000 0", pat_out, tdo);
    end
    #1 trst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, '0);

    tag = "R2"; seed(18'h2A5C3, 0); readback(0);
    tag = "R9"; seed(18'h15A3C, 0);
    tag = "R6"; run(2, 40);
    tag = "R6"; seed(18'h00000, 0); run(2, 3);
    tag = "R4"; for (int i = 0; i < 5; i++) cyc(0, 0, 2, 0, 18'($urandom));
    tag = "R4"; run(5, 4); run(0, 3); run(7, 3);
    tag = "R5"; seed(18'h3FFFF, 0); run(1, 30);
    tag = "R2"; readback(1);
    tag = "R7"; seed(18'h3FFFD, 0); run(3, 6);
    tag = "R8"; cyc(1, 0, 4, 0, 18'h0F0F0); run(4, 6);
    tag = "R8"; cyc(0, 0, 0, 0, '0); cyc(1, 0, 4, 0, 18'h12345); run(4, 3);
    tag = "R8"; seed(18'h00FF1, 4); run(4, 2);
    tag = "R3"; seed(18'h1ACE5, 0); run(2, 3);
    for (int i = 0; i < 6; i++) cyc(1, 1, 2, 1'(i), 18'($urandom));
    run(2, 2); readback(2);
    cyc(0, 0, 0, 0, '0);
    @(negedge tck);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule